// File: doc/BRIEF.md
# Concatenated Packet Transmit Controller

This block sits on the physical-layer side of a PHY/LINK interface. It runs on the interface clock and follows the link's 2-bit control lines and 2-bit data lines while the link has the interface. It finds the end of each packet the link sends. It works out whether the link held the bus for a follow-on packet, and chooses the speed of that packet. It then does one of two things. It waits a programmable separation gap and hands the interface back with a Transmit code. Or, when the follow-on request would drop to the slowest speed after a faster packet, it gives up the bus and reports the request for ordinary arbitration. It also recognises when the link abandons a transmission, which causes an empty packet on the serial bus.

The arbitration logic outside this block starts a transmission with a one-cycle start pulse and the granted speed. The block then drives Transmit on the control lines for one cycle and lets the link drive. The block moves no data stream, so it has no valid/ready handshake. Every pin is a plain level or a one-cycle pulse.

Encodings used throughout:
- Control codes: Idle = 00, Hold = 01, Receive = 10, Transmit = 11.
- Speed codes: 00 = S100, 01 = S200, 10 = S400. Code 11 is read as S400.

Top module: `cpt_ctrl`

## Requirements
- R1: After reset, and whenever `rst_n` is low, the block is in its idle state. `link_owns_o` = 0, `phy_ctl_o` = 00, `cur_speed_o` = 00 (S100), and all three event outputs are 0.
- R2: A `start_i` pulse in the idle state produces one cycle of `phy_ctl_o` = 11 with `evt_grant_o` = 1. In the next cycle `link_owns_o` = 1. `cur_speed_o` takes `start_speed_i`, with 11 stored as 10. A `start_i` pulse while the block is not idle has no effect.
- R3: While the link owns the interface, a link code of 10 or 11 marks a data cycle. The first Idle (00) after one or more data cycles ends the packet. The link keeps the interface for one more tail cycle, then `link_owns_o` falls with no event pulse.
- R4: A Hold (01) in place of that first Idle requests concatenation. After the tail cycle, `phy_ctl_o` stays 00 for exactly `min_sep_i` cycles, then drives 11 with `evt_grant_o` for one cycle. When `min_sep_i` = 0, the grant comes in the cycle right after the tail.
- R5: With `enab_multi_i` = 0, a concatenated packet keeps `cur_speed_o` of the previous packet, whatever `link_d_i` carries.
- R6: With `enab_multi_i` = 1, a concatenated packet takes its speed from `link_d_i` in the Hold cycle, with 11 stored as 10. `cur_speed_o` never reads 11.
- R7: A concatenation request for S100 after a packet at S200 or S400 is not granted. Instead `evt_demote_o` pulses in the cycle after the tail, the block returns to idle, and `cur_speed_o` keeps the previous packet's speed.
- R8: If the link, after taking the interface, drives Idle for three consecutive cycles with no data cycle and no Hold, `evt_cancel_o` pulses and the block returns to idle.
- R9: If the link drives Hold before any data cycle and then Idle for two consecutive cycles, `evt_cancel_o` pulses and the block returns to idle.
- R10: While the block owns the interface (idle, separation gap, grant cycle), the link control lines have no effect. In particular, Idle cycles during the separation gap cause no cancel and do not move the grant.
- R11: At most one of `evt_grant_o`, `evt_demote_o`, `evt_cancel_o` is high in any cycle. Demote and cancel pulses last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arbitration won; start a fresh transmission |
| start_speed_i | input | 2 | Speed granted with `start_i` |
| link_ctl_i | input | 2 | Control code driven by the link |
| link_d_i | input | 2 | Data lines from the link; speed code in the Hold cycle |
| enab_multi_i | input | 1 | 1: a concatenated packet speed comes from the link; 0: it keeps the previous speed |
| min_sep_i | input | SEP_W | Separation gap in clock cycles |
| phy_ctl_o | output | 2 | Control code driven by this block (00 or 11) |
| link_owns_o | output | 1 | 1 while the link drives the interface |
| cur_speed_o | output | 2 | Speed of the packet in flight or last sent |
| evt_grant_o | output | 1 | Pulse: Transmit handed to the link |
| evt_demote_o | output | 1 | Pulse: S100 concatenation turned into an arbitration request |
| evt_cancel_o | output | 1 | Pulse: link abandoned the transmission |

## Verification
The main function is tried with a set of concatenation cases. Each case combines the speed-selection bit, a first-packet speed, a speed code on the data lines in the Hold cycle, and a separation length.

- Cases where the data lines disagree with the previous speed show whether the selection bit chooses the source.
- An S100 request after S200 and after S400 shows the demotion apart from a normal grant.
- An S100-to-S100 case shows that the demotion does not fire when the speed does not fall.
- The raw code 11 checks the S400 mapping.
- Separation lengths of zero, one and several cycles fix the grant cycle exactly.

Directed runs cover the following:
- Both cancel patterns, each stopped one cycle short to show the count.
- A plain end of packet without Hold.
- A start pulse while the block is busy.
- Reset in the middle of a transmission.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  localparam logic [1:0] CTL_IDLE = 2'b00;
  localparam logic [1:0] CTL_HOLD = 2'b01;
  localparam logic [1:0] CTL_RECV = 2'b10;
  localparam logic [1:0] CTL_XMIT = 2'b11;

  localparam logic [1:0] SPD_S100 = 2'b00;
  localparam logic [1:0] SPD_S200 = 2'b01;
  localparam logic [1:0] SPD_S400 = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GRANT = 3'd1,
    ST_LINK  = 3'd2,
    ST_TAIL  = 3'd3,
    ST_SEP   = 3'd4
  } cpt_state_t;

  // map the raw 2-bit speed code onto the three legal speeds
  function automatic logic [1:0] norm_spd(input logic [1:0] raw);
    return (raw == 2'b11) ? SPD_S400 : raw;
  endfunction

endpackage

// File: rtl/cpt_link_mon.sv
// Follows link-driven control codes while the link owns the interface.
// Flags end of packet (with or without Hold) and both cancel patterns.
module cpt_link_mon
  import cpt_pkg::*;
#(
  parameter int IDLE_CANCEL = 3,
  parameter int HOLD_CANCEL = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] ctl,
  output logic       eop,
  output logic       eop_hold,
  output logic       cancel
);

  localparam int RUN_W = $clog2(IDLE_CANCEL + 1);

  logic             data_seen;
  logic             pre_hold;
  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] run_nxt;
  logic [RUN_W-1:0] limit;
  logic             is_data;

  assign is_data  = ctl[1];
  assign run_nxt  = run + RUN_W'(1);
  assign limit    = pre_hold ? RUN_W'(HOLD_CANCEL) : RUN_W'(IDLE_CANCEL);

  assign eop      = active && data_seen && !is_data;
  assign eop_hold = eop && (ctl == CTL_HOLD);
  assign cancel   = active && !data_seen && (ctl == CTL_IDLE) && (run_nxt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      data_seen <= 1'b0;
      pre_hold  <= 1'b0;
      run       <= '0;
    end else if (is_data) begin
      data_seen <= 1'b1;
      pre_hold  <= 1'b0;
      run       <= '0;
    end else if (!data_seen) begin
      if (ctl == CTL_HOLD) begin
        pre_hold <= 1'b1;
        run      <= '0;
      end else begin
        run <= run_nxt;
      end
    end
  end

endmodule

// File: rtl/cpt_sep_timer.sv
// Counts the separation gap between a held packet and the next grant.
module cpt_sep_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  input  logic         run,
  output logic         done
);

  logic [W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - W'(1);
    end else if (run && !done) begin
      cnt <= cnt - W'(1);
    end
  end

endmodule

// File: rtl/cpt_speed_pick.sv
// Chooses the speed of a concatenated packet and flags an illegal slowdown.
module cpt_speed_pick
  import cpt_pkg::*;
(
  input  logic       enab_multi,
  input  logic [1:0] prev_spd,
  input  logic [1:0] req_raw,
  output logic [1:0] next_spd,
  output logic       demote
);

  always_comb begin
    next_spd = enab_multi ? norm_spd(req_raw) : prev_spd;
    demote   = (next_spd == SPD_S100) && (prev_spd != SPD_S100);
  end

endmodule

// File: rtl/cpt_ctrl.sv
module cpt_ctrl
  import cpt_pkg::*;
#(
  parameter int SEP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       start_speed_i,
  input  logic [1:0]       link_ctl_i,
  input  logic [1:0]       link_d_i,
  input  logic             enab_multi_i,
  input  logic [SEP_W-1:0] min_sep_i,
  output logic [1:0]       phy_ctl_o,
  output logic             link_owns_o,
  output logic [1:0]       cur_speed_o,
  output logic             evt_grant_o,
  output logic             evt_demote_o,
  output logic             evt_cancel_o
);

  cpt_state_t state, state_nxt;
  logic [1:0] cur_spd;
  logic [1:0] held_spd;
  logic       held_req;
  logic       demote_q;
  logic       cancel_q;

  logic       mon_active;
  logic       mon_eop;
  logic       mon_eop_hold;
  logic       mon_cancel;
  logic [1:0] pick_spd;
  logic       pick_demote;
  logic       sep_load;
  logic       sep_done;
  logic       sep_zero;

  assign mon_active = (state == ST_LINK);
  assign sep_zero   = (min_sep_i == '0);

  cpt_link_mon #(
    .IDLE_CANCEL(3),
    .HOLD_CANCEL(2)
  ) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (mon_active),
    .ctl      (link_ctl_i),
    .eop      (mon_eop),
    .eop_hold (mon_eop_hold),
    .cancel   (mon_cancel)
  );

  cpt_speed_pick u_pick (
    .enab_multi (enab_multi_i),
    .prev_spd   (cur_spd),
    .req_raw    (held_spd),
    .next_spd   (pick_spd),
    .demote     (pick_demote)
  );

  cpt_sep_timer #(
    .W(SEP_W)
  ) u_sep (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sep_load),
    .len   (min_sep_i),
    .run   (state == ST_SEP),
    .done  (sep_done)
  );

  always_comb begin
    state_nxt = state;
    sep_load  = 1'b0;
    unique case (state)
      ST_IDLE:  if (start_i) state_nxt = ST_GRANT;
      ST_GRANT: state_nxt = ST_LINK;
      ST_LINK: begin
        if (mon_cancel)   state_nxt = ST_IDLE;
        else if (mon_eop) state_nxt = ST_TAIL;
      end
      ST_TAIL: begin
        if (!held_req || pick_demote) begin
          state_nxt = ST_IDLE;
        end else if (sep_zero) begin
          state_nxt = ST_GRANT;
        end else begin
          state_nxt = ST_SEP;
          sep_load  = 1'b1;
        end
      end
      ST_SEP:   if (sep_done) state_nxt = ST_GRANT;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_spd  <= SPD_S100;
      held_spd <= SPD_S100;
      held_req <= 1'b0;
      demote_q <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      state    <= state_nxt;
      demote_q <= 1'b0;
      cancel_q <= 1'b0;
      if (state == ST_IDLE && start_i) begin
        cur_spd <= norm_spd(start_speed_i);
      end
      if (state == ST_LINK) begin
        if (mon_cancel) begin
          cancel_q <= 1'b1;
        end else if (mon_eop) begin
          held_req <= mon_eop_hold;
          held_spd <= link_d_i;
        end
      end
      if (state == ST_TAIL && held_req) begin
        if (pick_demote) demote_q <= 1'b1;
        else             cur_spd  <= pick_spd;
      end
    end
  end

  assign phy_ctl_o    = (state == ST_GRANT) ? CTL_XMIT : CTL_IDLE;
  assign link_owns_o  = (state == ST_LINK) || (state == ST_TAIL);
  assign cur_speed_o  = cur_spd;
  assign evt_grant_o  = (state == ST_GRANT);
  assign evt_demote_o = demote_q;
  assign evt_cancel_o = cancel_q;

endmodule

// File: rtl/cpt_ctrl_chk.sv
module cpt_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] link_ctl_i,
  input logic [1:0] phy_ctl_o,
  input logic       link_owns_o,
  input logic [1:0] cur_speed_o,
  input logic       evt_grant_o,
  input logic       evt_demote_o,
  input logic       evt_cancel_o
);

  // R11
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_grant_o, evt_demote_o, evt_cancel_o}));

  // R11
  demote_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_demote_o |=> !evt_demote_o);

  // R11
  cancel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cancel_o |=> !evt_cancel_o);

  // R2
  grant_hand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_grant_o |=> link_owns_o);

  // R10
  owner_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_owns_o |-> phy_ctl_o == 2'b00);

  // R8
  cancel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cancel_o |-> $past(link_owns_o) && $past(link_ctl_i) == 2'b00);

  // R7
  demote_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_demote_o |-> $past(cur_speed_o) != 2'b00 && $stable(cur_speed_o));

  // R6
  spd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_speed_o != 2'b11);

endmodule

bind cpt_ctrl cpt_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_ctl_i   (link_ctl_i),
  .phy_ctl_o    (phy_ctl_o),
  .link_owns_o  (link_owns_o),
  .cur_speed_o  (cur_speed_o),
  .evt_grant_o  (evt_grant_o),
  .evt_demote_o (evt_demote_o),
  .evt_cancel_o (evt_cancel_o)
);

// File: tb/cpt_ctrl_tb.sv
`timescale 1ns/1ps
module cpt_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] start_speed_i = 2'b00;
  logic [1:0] link_ctl_i = 2'b00;
  logic [1:0] link_d_i = 2'b00;
  logic       enab_multi_i = 1'b0;
  logic [7:0] min_sep_i = 8'd0;
  logic [1:0] phy_ctl_o;
  logic       link_owns_o;
  logic [1:0] cur_speed_o;
  logic       evt_grant_o;
  logic       evt_demote_o;
  logic       evt_cancel_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cpt_ctrl #(.SEP_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_speed_i(start_speed_i),
    .link_ctl_i(link_ctl_i), .link_d_i(link_d_i), .enab_multi_i(enab_multi_i),
    .min_sep_i(min_sep_i), .phy_ctl_o(phy_ctl_o), .link_owns_o(link_owns_o),
    .cur_speed_o(cur_speed_o), .evt_grant_o(evt_grant_o),
    .evt_demote_o(evt_demote_o), .evt_cancel_o(evt_cancel_o)
  );

  // fields: enab, first speed, hold-cycle D, min_sep, demote expected, expected speed
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 2'd1, 2'd0, 4'd3, 1'b0, 2'd1},
    {1'b1, 2'd1, 2'd2, 4'd2, 1'b0, 2'd2},
    {1'b1, 2'd2, 2'd0, 4'd2, 1'b1, 2'd2},
    {1'b1, 2'd0, 2'd0, 4'd0, 1'b0, 2'd0},
    {1'b1, 2'd0, 2'd3, 4'd1, 1'b0, 2'd2},
    {1'b1, 2'd1, 2'd0, 4'd4, 1'b1, 2'd1},
    {1'b0, 2'd2, 2'd0, 4'd0, 1'b0, 2'd2},
    {1'b1, 2'd2, 2'd1, 4'd5, 1'b0, 2'd1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] ctl, input logic [1:0] d);
    link_ctl_i = ctl;
    link_d_i   = d;
    @(posedge clk);
    #1;
  endtask

  task automatic begin_tx(input logic [1:0] spd);
    start_i = 1'b1;
    start_speed_i = spd;
    step(2'b00, 2'b00);
    start_i = 1'b0;
  endtask

  task automatic run_vec(input logic [11:0] v);
    logic [1:0] s0, dsp, expv;
    int sep, bad;
    logic en, dem;
    en = v[11]; s0 = v[10:9]; dsp = v[8:7]; sep = int'(v[6:3]); dem = v[2]; expv = v[1:0];
    enab_multi_i = en;
    min_sep_i = 8'(sep);
    begin_tx(s0);
    chk("R2", "grant ctl", phy_ctl_o, 3);
    step(2'b11, 2'b00);
    chk("R2", "link owns", link_owns_o, 1);
    step(2'b11, 2'b00);
    step(2'b11, 2'b00);
    step(2'b01, dsp);
    step(2'b00, 2'b00);
    if (dem) begin
      chk("R7", "demote pulse", evt_demote_o, 1);
      chk("R7", "owner after demote", link_owns_o, 0);
      chk("R7", "speed kept", cur_speed_o, (s0 == 2'b11) ? 2 : s0);
      step(2'b00, 2'b00);
      chk("R11", "demote width", evt_demote_o, 0);
    end else begin
      bad = 0;
      for (int i = 0; i < sep; i++) begin
        if (phy_ctl_o != 2'b00 || evt_grant_o || evt_cancel_o) bad++;
        step(2'b00, 2'b00);
      end
      chk("R4", "gap quiet (R10 idle ignored)", bad, 0);
      chk("R4", "grant after gap", evt_grant_o, 1);
      chk(en ? "R6" : "R5", "concat speed", cur_speed_o, expv);
      step(2'b11, 2'b00);
      step(2'b11, 2'b00);
      step(2'b00, 2'b00);
      step(2'b00, 2'b00);
      chk("R3", "second packet released", link_owns_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "owner", link_owns_o, 0);
    chk("R1", "ctl", phy_ctl_o, 0);
    chk("R1", "speed", cur_speed_o, 0);
    chk("R1", "events", {evt_grant_o, evt_demote_o, evt_cancel_o}, 0);

    foreach (VEC[k]) run_vec(VEC[k]);

    // R2 speed 11 stored as S400, R3 plain end of packet
    enab_multi_i = 1'b1;
    begin_tx(2'b11);
    chk("R2", "start speed mapped", cur_speed_o, 2);
    step(2'b11, 2'b00);
    step(2'b11, 2'b00);
    step(2'b00, 2'b00);
    chk("R3", "tail still link", link_owns_o, 1);
    step(2'b00, 2'b00);
    chk("R3", "released", link_owns_o, 0);
    chk("R3", "no event", {evt_grant_o, evt_demote_o, evt_cancel_o}, 0);

    // R2 start ignored while busy
    begin_tx(2'b01);
    step(2'b11, 2'b00);
    start_i = 1'b1;
    start_speed_i = 2'b00;
    step(2'b11, 2'b00);
    start_i = 1'b0;
    chk("R2", "busy start no grant", evt_grant_o, 0);
    chk("R2", "busy start speed kept", cur_speed_o, 1);
    step(2'b00, 2'b00);
    step(2'b00, 2'b00);

    // R8 three idles cancel
    begin_tx(2'b00);
    step(2'b00, 2'b00);
    step(2'b00, 2'b00);
    step(2'b00, 2'b00);
    chk("R8", "two idles keep", link_owns_o, 1);
    step(2'b00, 2'b00);
    chk("R8", "cancel pulse", evt_cancel_o, 1);
    chk("R8", "released", link_owns_o, 0);
    step(2'b00, 2'b00);
    chk("R11", "cancel width", evt_cancel_o, 0);

    // R9 hold then two idles cancel
    begin_tx(2'b00);
    step(2'b00, 2'b00);
    step(2'b01, 2'b00);
    step(2'b00, 2'b00);
    chk("R9", "one idle keeps", link_owns_o, 1);
    step(2'b00, 2'b00);
    chk("R9", "cancel pulse", evt_cancel_o, 1);

    // R1 reset mid-transmission
    begin_tx(2'b10);
    step(2'b11, 2'b00);
    rst_n = 1'b0;
    step(2'b11, 2'b00);
    chk("R1", "owner in reset", link_owns_o, 0);
    chk("R1", "speed in reset", cur_speed_o, 0);
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule